// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is the command front end of a small NOR-style flash store. A host drives it through an asynchronous-looking parallel bus (select, write strobe, read strobe, 12-bit address, 16-bit data), which the block samples on its own clock. A write is recognised on the clock where the write strobe falls while the chip is selected. A read is counted on the clock where the read strobe falls. The block decodes multi-write unlock sequences and starts word programs and sector erases on an internal array of `2**SECT_W` sectors with `2**WORD_W` words each. Each operation lasts a fixed number of clocks.

While an operation runs, reads return a status word instead of array data. A ready output shows when the block can accept new work. A bypass mode shortens programming to two writes. An erase can be paused to read or program other sectors, and a program can be paused to read other sectors. The active-low reset stops any operation and clears any partial sequence. It leaves the array contents untouched.

Command writes compare the low byte of the data. The two unlock writes are `0xAA` at address `0x555` and `0x55` at address `0x2AA`. The array word index is the low `SECT_W+WORD_W` address bits, with the sector number in the upper part of that index.

Top module: `nor_fcsm_top`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `rdy` is 1 and no operation is running.
- R2: The writes AA@0x555, 55@0x2AA, A0@0x555 and then data D at address A start a program of word A. Once it completes, `rdy` returns to 1 and reading A gives the new word.
- R3: A program stores the old word AND D, so it can only clear bits.
- R4: `rdy` is 0 for exactly `PGM_CYC` clock cycles for a program and exactly `ERS_CYC` cycles for an erase. The count starts on the cycle after the clock that accepts the last write. `rdy` only falls after an accepted write.
- R5: While an operation is running, every read returns a status word. Bit 7 is the complement of bit 7 of the data being programmed, and it is 0 for an erase. Bit 6 changes value between successive reads. All other bits are 0.
- R6: The writes AA@0x555, 55@0x2AA, 80@0x555, AA@0x555, 55@0x2AA and then 30 at any address in sector S set every word of S to 0xFFFF. Words in other sectors keep their values.
- R7: A write that does not match the next expected step of a sequence returns the block to read mode. That write and the writes before it start nothing and change no word.
- R8: AA@0x555, 55@0x2AA, 20@0x555 enters bypass mode. In bypass mode, A0 at any address followed by D at A programs word A. Writing 90 and then 00 leaves bypass mode. After that, a two-write program has no effect.
- R9: Writing B0 during an erase pauses it, and `rdy` is 1 from the next cycle. Reads of the paused sector return status. Other sectors read normally and can be programmed. A program aimed at the paused sector is dropped. Writing 30 resumes the erase and it completes.
- R10: Writing B0 during a program pauses it. Other sectors read normally, and reads of the paused word's sector return status. Writing 30 resumes the program and it completes with the expected value.
- R11: While an operation is running, every write other than B0 is ignored.
- R12: `rdata` is 0 whenever `bus_cs_n` or `bus_oe_n` is high.
- R13: Asserting reset during a program aborts it and leaves the target word unchanged. A partly entered sequence is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low hardware reset (asynchronous) |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_we_n | input | 1 | Write strobe, active low; a falling edge is one write |
| bus_oe_n | input | 1 | Read strobe, active low; a falling edge is one read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data; command code in bits 7:0 |
| rdata | output | DATA_W | Array word or status word during a read, otherwise 0 |
| rdy | output | 1 | 1 when no program or erase is running |

## Verification
The assertions rely on the host bus following a clean protocol:
- the write and read strobes are never low together while the chip is selected;
- each strobe returns high before its next use;
- the address stays constant during a read.

The status-stability property also assumes the read strobe is not re-pulsed inside one sampled cycle. The bench meets all of these by building every access from two tasks. Each task drives one strobe for exactly one clock and then releases select and the strobe for one clock. Random programs, reads, erases and broken sequences are all made from these same two tasks.

// File: rtl/nor_fcsm_pkg.sv
package nor_fcsm_pkg;

    typedef enum logic [2:0] {
        CS_READ,
        CS_UNL1,
        CS_UNL2,
        CS_PGM,
        CS_ESET,
        CS_EUNL1,
        CS_EUNL2,
        CS_BEXIT
    } cmd_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PGM,
        OP_ERS
    } op_e;

    localparam logic [7:0] K_UNL_A   = 8'hAA;
    localparam logic [7:0] K_UNL_B   = 8'h55;
    localparam logic [7:0] K_PROG    = 8'hA0;
    localparam logic [7:0] K_ESETUP  = 8'h80;
    localparam logic [7:0] K_SERASE  = 8'h30;
    localparam logic [7:0] K_SUSP    = 8'hB0;
    localparam logic [7:0] K_RESUME  = 8'h30;
    localparam logic [7:0] K_BYP_ON  = 8'h20;
    localparam logic [7:0] K_BYP_OFF = 8'h90;
    localparam logic [7:0] K_BYP_END = 8'h00;

    localparam logic [11:0] A_UNL_A = 12'h555;
    localparam logic [11:0] A_UNL_B = 12'h2AA;

endpackage

// File: rtl/nor_fcsm_bus.sv
module nor_fcsm_bus (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_cs_n,
    input  logic bus_we_n,
    input  logic bus_oe_n,
    output logic wr_stb,
    output logic rd_stb
);
    logic we_d, we_q;
    logic oe_d, oe_q;

    always_comb begin
        we_d   = bus_we_n;
        oe_d   = bus_oe_n;
        wr_stb = !bus_cs_n && !bus_we_n && bus_oe_n && we_q;
        rd_stb = !bus_cs_n && !bus_oe_n && bus_we_n && oe_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            oe_q <= 1'b1;
        end else begin
            we_q <= we_d;
            oe_q <= oe_d;
        end
    end
endmodule

// File: rtl/nor_fcsm_dec.sv
module nor_fcsm_dec
    import nor_fcsm_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        code,
    output logic              unl_a,
    output logic              unl_b,
    output logic              at_cmd
);
    always_comb begin
        at_cmd = (addr == ADDR_W'(A_UNL_A));
        unl_a  = at_cmd && (code == K_UNL_A);
        unl_b  = (addr == ADDR_W'(A_UNL_B)) && (code == K_UNL_B);
    end
endmodule

// File: rtl/nor_fcsm_array.sv
module nor_fcsm_array #(
    parameter int SECT_W = 2,
    parameter int WORD_W = 4,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     pgm_en,
    input  logic [SECT_W+WORD_W-1:0] pgm_idx,
    input  logic [DATA_W-1:0]        pgm_val,
    input  logic                     ers_en,
    input  logic [SECT_W-1:0]        ers_sect,
    input  logic [SECT_W+WORD_W-1:0] rd_idx,
    output logic [DATA_W-1:0]        rd_data
);
    localparam int WPS    = 1 << WORD_W;
    localparam int NWORDS = 1 << (SECT_W + WORD_W);

    logic [DATA_W-1:0] mem_q [NWORDS];

    always_ff @(posedge clk) begin
        if (pgm_en)
            mem_q[pgm_idx] <= mem_q[pgm_idx] & pgm_val;
        if (ers_en)
            for (int w = 0; w < WPS; w++)
                mem_q[{ers_sect, WORD_W'(w)}] <= '1;
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/nor_fcsm_top.sv
module nor_fcsm_top
    import nor_fcsm_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 16,
    parameter int SECT_W  = 2,
    parameter int WORD_W  = 4,
    parameter int PGM_CYC = 8,
    parameter int ERS_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdy
);
    localparam int IDX_W = SECT_W + WORD_W;
    localparam int MAXC  = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        cmd_e              cmd;
        logic              byp;
        op_e               op;
        logic              esus;
        logic              psus;
        logic [CNT_W-1:0]  pcnt;
        logic [CNT_W-1:0]  ecnt;
        logic [IDX_W-1:0]  paddr;
        logic [DATA_W-1:0] pdata;
        logic [SECT_W-1:0] esect;
        logic              tog;
    } st_t;

    st_t s_d, s_q;

    logic wr_stb, rd_stb;
    logic unl_a, unl_b, at_cmd;
    logic arr_pgm, arr_ers, op_done;
    logic [DATA_W-1:0] arr_rd, rd_val, stat_w;
    logic [7:0]        code;
    logic [SECT_W-1:0] wsect, psect_w;
    logic [IDX_W-1:0]  widx;
    logic              esus_w;

    assign code    = wdata[7:0];
    assign widx    = addr[IDX_W-1:0];
    assign wsect   = addr[IDX_W-1:WORD_W];
    assign psect_w = s_q.paddr[IDX_W-1:WORD_W];
    assign esus_w  = s_q.esus;

    nor_fcsm_bus i_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_cs_n (bus_cs_n),
        .bus_we_n (bus_we_n),
        .bus_oe_n (bus_oe_n),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb)
    );

    nor_fcsm_dec #(.ADDR_W(ADDR_W)) i_dec (
        .addr   (addr),
        .code   (code),
        .unl_a  (unl_a),
        .unl_b  (unl_b),
        .at_cmd (at_cmd)
    );

    nor_fcsm_array #(.SECT_W(SECT_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) i_arr (
        .clk      (clk),
        .pgm_en   (arr_pgm),
        .pgm_idx  (s_q.paddr),
        .pgm_val  (s_q.pdata),
        .ers_en   (arr_ers),
        .ers_sect (s_q.esect),
        .rd_idx   (widx),
        .rd_data  (arr_rd)
    );

    // next-state computation
    always_comb begin
        s_d     = s_q;
        arr_pgm = 1'b0;
        arr_ers = 1'b0;
        op_done = 1'b0;

        // embedded operation timing
        case (s_q.op)
            OP_PGM: begin
                if (s_q.pcnt == '0) begin
                    arr_pgm = 1'b1;
                    op_done = 1'b1;
                    s_d.op  = OP_NONE;
                end else begin
                    s_d.pcnt = s_q.pcnt - 1'b1;
                end
            end
            OP_ERS: begin
                if (s_q.ecnt == '0) begin
                    arr_ers = 1'b1;
                    op_done = 1'b1;
                    s_d.op  = OP_NONE;
                end else begin
                    s_d.ecnt = s_q.ecnt - 1'b1;
                end
            end
            default: ;
        endcase

        if (rd_stb && s_q.op != OP_NONE)
            s_d.tog = ~s_q.tog;

        if (wr_stb) begin
            if (s_q.op != OP_NONE) begin
                // busy: only a pause request is honoured
                if (!op_done && code == K_SUSP) begin
                    if (s_q.op == OP_PGM) s_d.psus = 1'b1;
                    else                  s_d.esus = 1'b1;
                    s_d.op = OP_NONE;
                end
            end else if (s_q.cmd == CS_READ && (s_q.psus || s_q.esus) && code == K_RESUME) begin
                if (s_q.psus) begin
                    s_d.psus = 1'b0;
                    s_d.op   = OP_PGM;
                end else begin
                    s_d.esus = 1'b0;
                    s_d.op   = OP_ERS;
                end
            end else begin
                s_d.cmd = CS_READ;
                case (s_q.cmd)
                    CS_READ: begin
                        if (s_q.byp) begin
                            if (code == K_PROG)         s_d.cmd = CS_PGM;
                            else if (code == K_BYP_OFF) s_d.cmd = CS_BEXIT;
                        end else if (unl_a) begin
                            s_d.cmd = CS_UNL1;
                        end
                    end
                    CS_UNL1: if (unl_b) s_d.cmd = CS_UNL2;
                    CS_UNL2: begin
                        if (at_cmd && !s_q.psus) begin
                            if (code == K_PROG)
                                s_d.cmd = CS_PGM;
                            else if (code == K_ESETUP && !s_q.esus)
                                s_d.cmd = CS_ESET;
                            else if (code == K_BYP_ON && !s_q.esus)
                                s_d.byp = 1'b1;
                        end
                    end
                    CS_PGM: begin
                        if (!s_q.psus && !(s_q.esus && wsect == s_q.esect)) begin
                            s_d.op    = OP_PGM;
                            s_d.pcnt  = CNT_W'(PGM_CYC - 1);
                            s_d.paddr = widx;
                            s_d.pdata = wdata;
                        end
                    end
                    CS_ESET:  if (unl_a) s_d.cmd = CS_EUNL1;
                    CS_EUNL1: if (unl_b) s_d.cmd = CS_EUNL2;
                    CS_EUNL2: begin
                        if (code == K_SERASE) begin
                            s_d.op    = OP_ERS;
                            s_d.ecnt  = CNT_W'(ERS_CYC - 1);
                            s_d.esect = wsect;
                        end
                    end
                    CS_BEXIT: if (code == K_BYP_END) s_d.byp = 1'b0;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // read path
    always_comb begin
        stat_w    = '0;
        stat_w[6] = s_q.tog;
        rd_val    = arr_rd;
        if (s_q.op == OP_PGM) begin
            stat_w[7] = ~s_q.pdata[7];
            rd_val    = stat_w;
        end else if (s_q.op == OP_ERS) begin
            rd_val = stat_w;
        end else if (s_q.psus && wsect == psect_w) begin
            stat_w[7] = ~s_q.pdata[7];
            rd_val    = stat_w;
        end else if (esus_w && wsect == s_q.esect) begin
            rd_val = stat_w;
        end
        rdata = (!bus_cs_n && !bus_oe_n) ? rd_val : '0;
        rdy   = (s_q.op == OP_NONE);
    end
endmodule

// File: rtl/nor_fcsm_chk.sv
module nor_fcsm_chk #(
    parameter int DATA_W = 16,
    parameter int SECT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs_n,
    input logic              bus_oe_n,
    input logic              rdy,
    input logic [DATA_W-1:0] rdata,
    input logic              wr_stb,
    input logic              arr_pgm,
    input logic              arr_ers,
    input logic              esus,
    input logic [SECT_W-1:0] psect,
    input logic [SECT_W-1:0] esect
);
    assert_quiet_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs_n || bus_oe_n) |-> (rdata == '0));

    assert_status_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && !bus_cs_n && !bus_oe_n) |-> (rdata[DATA_W-1:8] == '0 && rdata[5:0] == '0));

    assert_toggle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && $past(!rdy) && !bus_cs_n && !bus_oe_n && $past(!bus_cs_n) && $past(!bus_oe_n))
        |-> (rdata[6] == $past(rdata[6])));

    assert_busy_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> $past(wr_stb));

    assert_done_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_pgm || arr_ers) |=> rdy);

    assert_paused_sector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_pgm |-> !(esus && psect == esect));
endmodule

bind nor_fcsm_top nor_fcsm_chk #(.DATA_W(DATA_W), .SECT_W(SECT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_cs_n (bus_cs_n),
    .bus_oe_n (bus_oe_n),
    .rdy      (rdy),
    .rdata    (rdata),
    .wr_stb   (wr_stb),
    .arr_pgm  (arr_pgm),
    .arr_ers  (arr_ers),
    .esus     (esus_w),
    .psect    (psect_w),
    .esect    (s_q.esect)
);

// File: tb/test_nor_fcsm_top.sv
`timescale 1ns/1ps
module test_nor_fcsm_top;
    localparam int PGM_CYC = 8;
    localparam int ERS_CYC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rdy;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] ref_mem [64];

    always #2.5 clk = ~clk;

    nor_fcsm_top #(.PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)) i_nor_fcsm_top (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdy(rdy)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        cs_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        we_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        cs_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
        oe_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_timed(input logic [11:0] a, input logic [15:0] d, output int cyc);
        cs_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        we_n = 1'b1; cs_n = 1'b1;
        cyc = 0;
        while (!rdy && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic wait_rdy();
        int n = 0;
        while (!rdy && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(rdy, "R4 ready after operation", {15'b0, rdy}, 16'h1);
    endtask

    task automatic unlock3(input logic [7:0] c);
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
        wr(12'h555, {8'h00, c});
    endtask

    task automatic prog4(input int idx, input logic [15:0] d);
        unlock3(8'hA0);
        wr(12'(idx), d);
    endtask

    task automatic erase_pre();
        unlock3(8'h80);
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
    endtask

    task automatic check_word(input int idx, input string tag);
        logic [15:0] v;
        rd(12'(idx), v);
        chk(v === ref_mem[idx], tag, v, ref_mem[idx]);
    endtask

    function automatic logic [15:0] pgm_model(input logic [15:0] old, input logic [15:0] d);
        return old & d;
    endfunction

    task automatic erase_model(input int s);
        for (int w = 0; w < 16; w++) ref_mem[s*16 + w] = 16'hFFFF;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v1, v2;
        int cyc;
        void'($urandom(32'd1301));
        repeat (3) @(negedge clk);
        chk(rdy === 1'b1, "R1 ready during reset", {15'b0, rdy}, 16'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdy === 1'b1, "R1 ready after reset", {15'b0, rdy}, 16'h1);
        cs_n = 1'b0; oe_n = 1'b1; addr = 12'h005;
        @(negedge clk);
        chk(rdata === 16'h0, "R12 no output without read strobe", rdata, 16'h0);
        cs_n = 1'b1;
        @(negedge clk);

        // erase everything, first one timed
        erase_pre();
        wr_timed(12'h000, 16'h0030, cyc);
        chk(cyc == ERS_CYC, "R4 erase busy length", 16'(cyc), 16'(ERS_CYC));
        for (int s = 1; s < 4; s++) begin
            erase_pre();
            wr(12'(s*16), 16'h0030);
            wait_rdy();
        end
        for (int s = 0; s < 4; s++) erase_model(s);
        check_word(0, "R6 erased word");
        check_word(63, "R6 erased word");

        // four-write program, timed
        unlock3(8'hA0);
        wr_timed(12'd5, 16'h1234, cyc);
        chk(cyc == PGM_CYC, "R4 program busy length", 16'(cyc), 16'(PGM_CYC));
        ref_mem[5] = pgm_model(ref_mem[5], 16'h1234);
        check_word(5, "R2 programmed word");
        prog4(5, 16'hFF0F); wait_rdy();
        ref_mem[5] = pgm_model(ref_mem[5], 16'hFF0F);
        check_word(5, "R3 bits only clear");

        // status during program, data bit7 = 1
        prog4(9, 16'h0080);
        rd(12'd0, v1); rd(12'd40, v2);
        chk(v1 === 16'h0000 || v1 === 16'h0040, "R5 program status bit7 low", v1, 16'h0040);
        chk(v1[6] !== v2[6], "R5 toggle between reads", v2, ~v1);
        wait_rdy();
        ref_mem[9] = pgm_model(ref_mem[9], 16'h0080);
        // status during program, data bit7 = 0
        prog4(10, 16'h0F00);
        rd(12'd0, v1);
        chk((v1 & 16'hFFBF) === 16'h0080, "R5 program status bit7 high", v1, 16'h0080);
        wait_rdy();
        ref_mem[10] = pgm_model(ref_mem[10], 16'h0F00);

        // erase of sector 3 only, plus writes while busy
        prog4(8'h30, 16'h00F0); wait_rdy(); ref_mem[8'h30] = 16'h00F0;
        prog4(8'h20, 16'h5A5A); wait_rdy(); ref_mem[8'h20] = 16'h5A5A;
        erase_pre();
        wr(12'h030, 16'h0030);
        rd(12'h030, v1); rd(12'h010, v2);
        chk((v1 & 16'hFFBF) === 16'h0000, "R5 erase status", v1, 16'h0000);
        chk(v1[6] !== v2[6], "R5 erase toggle", v2, ~v1);
        prog4(2, 16'h0000);
        wait_rdy();
        erase_model(3);
        check_word(2, "R11 write while busy ignored");
        check_word(8'h30, "R6 addressed sector erased");
        check_word(8'h20, "R6 other sector kept");

        // broken sequences
        unlock3(8'h77); wr(12'h021, 16'h0000);
        chk(rdy === 1'b1, "R7 no op after bad command", {15'b0, rdy}, 16'h1);
        check_word(8'h21, "R7 bad command leaves word");
        wr(12'h555, 16'h00AA); wr(12'h2AB, 16'h0055); wr(12'h555, 16'h00A0); wr(12'h021, 16'h0000);
        check_word(8'h21, "R7 bad unlock address leaves word");

        // bypass
        unlock3(8'h20);
        wr(12'h000, 16'h00A0); wr(12'h022, 16'h0F0F); wait_rdy();
        ref_mem[8'h22] = 16'h0F0F;
        check_word(8'h22, "R8 bypass program");
        wr(12'h000, 16'h00A0); wr(12'h023, 16'h00FF); wait_rdy();
        ref_mem[8'h23] = 16'h00FF;
        check_word(8'h23, "R8 second bypass program");
        wr(12'h000, 16'h0090); wr(12'h000, 16'h0000);
        wr(12'h000, 16'h00A0); wr(12'h024, 16'h0000);
        chk(rdy === 1'b1, "R8 after exit two-write program idle", {15'b0, rdy}, 16'h1);
        check_word(8'h24, "R8 after exit word kept");

        // erase suspend
        prog4(8'h11, 16'h0000); wait_rdy(); ref_mem[8'h11] = 16'h0000;
        erase_pre();
        wr(12'h010, 16'h0030);
        wr(12'h000, 16'h00B0);
        chk(rdy === 1'b1, "R9 ready in erase pause", {15'b0, rdy}, 16'h1);
        rd(12'h011, v1);
        chk((v1 & 16'hFFBF) === 16'h0000, "R9 paused sector reads status", v1, 16'h0000);
        check_word(8'h22, "R9 other sector readable");
        prog4(8'h26, 16'h3C3C); wait_rdy(); ref_mem[8'h26] = 16'h3C3C;
        check_word(8'h26, "R9 program other sector in pause");
        prog4(8'h12, 16'h0000);
        chk(rdy === 1'b1, "R9 program to paused sector dropped", {15'b0, rdy}, 16'h1);
        wr(12'h000, 16'h0030);
        wait_rdy();
        erase_model(1);
        check_word(8'h11, "R9 resumed erase done");
        check_word(8'h12, "R9 dropped program left no trace");
        check_word(8'h26, "R9 pause program kept");

        // program suspend
        prog4(8'h31, 16'h0F00);
        wr(12'h000, 16'h00B0);
        chk(rdy === 1'b1, "R10 ready in program pause", {15'b0, rdy}, 16'h1);
        check_word(5, "R10 other sector readable");
        rd(12'h031, v1);
        chk((v1 & 16'hFFBF) === 16'h0080, "R10 paused sector status", v1, 16'h0080);
        wr(12'h000, 16'h0030);
        wait_rdy();
        ref_mem[8'h31] = pgm_model(ref_mem[8'h31], 16'h0F00);
        check_word(8'h31, "R10 resumed program done");

        // hardware reset
        prog4(8'h32, 16'h0000);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdy === 1'b1, "R13 ready after abort", {15'b0, rdy}, 16'h1);
        check_word(8'h32, "R13 aborted word unchanged");
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        wr(12'h555, 16'h00A0); wr(12'h033, 16'h0000);
        check_word(8'h33, "R13 partial sequence discarded");

        // random mix
        for (int i = 0; i < 80; i++) begin
            int kind, idx;
            logic [15:0] d;
            kind = int'($urandom % 4);
            idx  = int'($urandom % 64);
            d    = 16'($urandom);
            case (kind)
                0: begin
                    prog4(idx, d); wait_rdy();
                    ref_mem[idx] = pgm_model(ref_mem[idx], d);
                    check_word(idx, "R2 R3 random program");
                end
                1: check_word(idx, "R2 random read");
                2: begin
                    wr(12'h555, 16'h00AA);
                    wr(12'h2AA, (d[7:0] == 8'h55) ? 16'h0056 : d);
                    wr(12'(idx), 16'h0000);
                    chk(rdy === 1'b1, "R7 random broken idle", {15'b0, rdy}, 16'h1);
                    check_word(idx, "R7 random broken sequence");
                end
                default: begin
                    if (($urandom % 4) == 0) begin
                        erase_pre();
                        wr(12'(idx), 16'h0030); wait_rdy();
                        erase_model(idx / 16);
                        check_word(idx, "R6 random erase");
                    end else begin
                        unlock3(8'h20);
                        wr(12'h000, 16'h00A0); wr(12'(idx), d); wait_rdy();
                        wr(12'h000, 16'h0090); wr(12'h000, 16'h0000);
                        ref_mem[idx] = pgm_model(ref_mem[idx], d);
                        check_word(idx, "R8 random bypass program");
                    end
                end
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule